// File: doc/BRIEF.md
# Reloadable Prescaled Down-Counter Timer

This block is one timer channel for a larger timer unit. A 32-bit counter counts down once for each tick of a prescaler. The prescaler divides the block clock by 4, 16, 64, 256 or 1024. When the counter is at zero on a tick, it loads a programmed reload value and sets a sticky underflow flag. The interrupt output is that flag, gated by an enable bit.

The parent unit controls counting through a `start` input. Software reaches three word registers over a simple synchronous write port and a combinational read port: reload value, live count, and control. The word index selects the register: 0 is the reload value, 1 is the count, 2 is the control word. These sit at byte offsets 0, 4 and 8.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, the reload value and the count both read 0xFFFFFFFF, the control word reads 0, and `irq` is low.
- R2: Word index 0 selects the reload value, 1 the count and 2 the control word. Index 3 reads 0, and writes to it change nothing.
- R3: Control bits [2:0] select the prescale ratio. Code c gives one tick every 4^(c+1) clocks, so codes 0 to 4 give 4, 16, 64, 256 and 1024.
- R4: The count decreases by one on each prescaler tick, and only while `start` is high. While `start` is low, the count holds and reads unchanged.
- R5: On a tick where the count is 0, the count loads the reload value and the underflow flag (control bit 8) is set.
- R6: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag unchanged.
- R7: `irq` equals the underflow flag AND the interrupt enable (control bit 5).
- R8: A count write loads the counter directly. A reload write leaves the count unchanged and only sets the value used at the next reload.
- R9: Control bits 3, 4, 6, 7 and 9 to 15 read as 0, and writes to them are discarded. A write with a prescale code of 5 to 7 keeps the previous selection.
- R10: A control write that changes the prescale selection restarts the prescaler phase from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Count enable from the parent unit |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register word index |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Underflow interrupt request |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- a count write lands exactly;
- a tick decrements the count, and an underflow reloads it;
- the count stays still without a tick;
- ticks occur only while started;
- the prescaler phase stays within the selected ratio;
- a flag-preserving write leaves the flag unchanged.

Only the bench scenarios can show the long-range timing: the actual division ratio of each prescale code, the phase restart after a selection change, and how reserved codes and bits are handled as seen at the read port.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic tick;        // prescaled count tick
    logic loadCount;   // software write of the count register
    logic loadReload;  // software write of the reload register
  } dpStrobes_t;

  localparam logic [1:0] IDX_RELOAD = 2'd0;
  localparam logic [1:0] IDX_COUNT  = 2'd1;
  localparam logic [1:0] IDX_CTRL   = 2'd2;

  localparam int IE_BIT   = 5;
  localparam int FLAG_BIT = 8;
  localparam int SEL_W    = 3;
  localparam int SEL_MAX  = 4;

endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PS_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              underflow,
  output dpStrobes_t        strb,
  output logic [SEL_W-1:0]  sel,
  output logic              intEn,
  output logic              flag
);

  logic [PS_W-1:0]  psCnt;
  logic [PS_W-1:0]  psLimit;
  logic [SEL_W-1:0] newSel;
  logic             ctrlWr;
  logic             selChange;
  logic             psWrap;

  assign ctrlWr    = wrEn && (addr == IDX_CTRL);
  assign newSel    = (wrData[SEL_W-1:0] <= SEL_W'(SEL_MAX)) ? wrData[SEL_W-1:0] : sel;
  assign selChange = ctrlWr && (newSel != sel);
  assign psLimit   = PS_W'((32'd4 << {sel, 1'b0}) - 32'd1);
  assign psWrap    = (psCnt == psLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (selChange) begin
      psCnt <= '0;
    end else if (start) begin
      psCnt <= psWrap ? '0 : psCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sel   <= '0;
      intEn <= 1'b0;
    end else if (ctrlWr) begin
      sel   <= newSel;
      intEn <= wrData[IE_BIT];
    end
  end

  // An underflow in the same cycle as a clearing write wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (underflow) begin
      flag <= 1'b1;
    end else if (ctrlWr && !wrData[FLAG_BIT]) begin
      flag <= 1'b0;
    end
  end

  always_comb begin
    strb            = '0;
    strb.tick       = start && psWrap && !selChange;
    strb.loadCount  = wrEn && (addr == IDX_COUNT);
    strb.loadReload = wrEn && (addr == IDX_RELOAD);
  end

  assert_tick_needs_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |-> start);

  assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    psCnt <= psLimit);

  assert_sel_change_restarts_R10: assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> (psCnt == '0));

  assert_flag_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[FLAG_BIT] && !underflow) |=> (flag == $past(flag)));

  assert_underflow_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> flag);

endmodule

// File: rtl/reload_timer_datapath.sv
module reload_timer_datapath
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] ctrlWord,
  output logic              underflow,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] reload;
  logic              atZero;

  assign atZero    = (count == '0);
  assign underflow = strb.tick && atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reload <= '1;
    end else if (strb.loadReload) begin
      reload <= wrData;
    end
  end

  // A software write of the count wins over a tick in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '1;
    end else if (strb.loadCount) begin
      count <= wrData;
    end else if (strb.tick) begin
      count <= atZero ? reload : count - 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      IDX_RELOAD: rdData = reload;
      IDX_COUNT:  rdData = count;
      IDX_CTRL:   rdData = ctrlWord;
      default:    rdData = '0;
    endcase
  end

  assert_count_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> (count == $past(wrData)));

  assert_reload_on_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !strb.loadCount) |=> (count == $past(reload)));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !atZero && !strb.loadCount) |=> (count == $past(count) - 1'b1));

  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.loadCount) |=> $stable(count));

endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PS_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  dpStrobes_t        strb;
  logic [SEL_W-1:0]  sel;
  logic              intEn;
  logic              flag;
  logic              underflow;
  logic [DATA_W-1:0] ctrlWord;

  always_comb begin
    ctrlWord              = '0;
    ctrlWord[SEL_W-1:0]   = sel;
    ctrlWord[IE_BIT]      = intEn;
    ctrlWord[FLAG_BIT]    = flag;
  end

  assign irq = flag && intEn;

  reload_timer_ctrl #(.DATA_W(DATA_W), .PS_W(PS_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .underflow (underflow),
    .strb      (strb),
    .sel       (sel),
    .intEn     (intEn),
    .flag      (flag)
  );

  reload_timer_datapath #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .addr      (addr),
    .ctrlWord  (ctrlWord),
    .underflow (underflow),
    .rdData    (rdData)
  );

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rdDataCtrlBitsOk);

  logic rdDataCtrlBitsOk;
  assign rdDataCtrlBitsOk = (ctrlWord[IE_BIT] == 1'b1) && (ctrlWord[FLAG_BIT] == 1'b1);

endmodule

// File: tb/reload_down_timer_test.sv
module reload_down_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  localparam int VSEL [NVEC] = '{0, 1, 2, 3, 4};
  localparam int VINIT[NVEC] = '{10, 7, 3, 100, 50};
  localparam int VRUN [NVEC] = '{20, 48, 128, 512, 2048};
  localparam int VEXP [NVEC] = '{5, 4, 1, 98, 48};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_down_timer uut (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    start = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, v); check("R1 reload", v, 32'hFFFF_FFFF);
    readReg(2'd1, v); check("R1 count", v, 32'hFFFF_FFFF);
    readReg(2'd2, v); check("R1 ctrl", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R3 R4 R10: ratio table, live count read
    for (int i = 0; i < NVEC; i++) begin
      doWrite(2'd2, 32'(VSEL[i]));
      doWrite(2'd1, 32'(VINIT[i]));
      runTicks(VRUN[i]);
      readReg(2'd1, v);
      check($sformatf("R3 R4 ratio code %0d", VSEL[i]), v, 32'(VEXP[i]));
    end

    // R8: reload write leaves the count alone
    doWrite(2'd0, 32'd5);
    readReg(2'd1, v); check("R8 reload write keeps count", v, 32'd48);
    readReg(2'd0, v); check("R2 reload readback", v, 32'd5);

    // R5 R7: underflow reloads and raises irq
    doWrite(2'd2, 32'h20);
    doWrite(2'd1, 32'd1);
    runTicks(8);
    readReg(2'd1, v); check("R5 reload on underflow", v, 32'd5);
    readReg(2'd2, v); check("R5 flag set", v, 32'h120);
    check("R7 irq high", {31'b0, irq}, 32'h1);

    // R6: writing 1 keeps, writing 0 clears
    doWrite(2'd2, 32'h120);
    readReg(2'd2, v); check("R6 write one keeps flag", v, 32'h120);
    doWrite(2'd2, 32'h20);
    readReg(2'd2, v); check("R6 write zero clears flag", v, 32'h20);
    check("R7 irq low after clear", {31'b0, irq}, 32'h0);

    // R7: flag without enable
    doWrite(2'd2, 32'h0);
    runTicks(24);
    readReg(2'd2, v); check("R7 flag set enable off", v, 32'h100);
    check("R7 irq gated off", {31'b0, irq}, 32'h0);
    doWrite(2'd2, 32'h120);
    check("R7 irq after enable", {31'b0, irq}, 32'h1);

    // R9: reserved bits and codes
    doWrite(2'd2, 32'h122);
    readReg(2'd2, v); check("R9 sel two set", v, 32'h122);
    doWrite(2'd2, 32'hFC27);
    readReg(2'd2, v); check("R9 reserved discarded", v, 32'h22);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);

    // R2: index 3
    doWrite(2'd3, 32'hFFFF_FFFF);
    readReg(2'd3, v); check("R2 index three reads zero", v, 32'h0);
    readReg(2'd2, v); check("R2 index three no effect", v, 32'h22);

    // R4: holds while start low
    doWrite(2'd2, 32'h0);
    repeat (50) @(posedge clk);
    readReg(2'd1, v); check("R4 hold when stopped", v, 32'd5);

    // R10: phase restart on selection change
    runTicks(2);
    doWrite(2'd2, 32'h1);
    doWrite(2'd2, 32'h0);
    runTicks(3);
    readReg(2'd1, v); check("R10 phase restarted", v, 32'd5);
    runTicks(1);
    readReg(2'd1, v); check("R10 first tick after restart", v, 32'd4);

    // R8: direct count load
    doWrite(2'd1, 32'h1234);
    readReg(2'd1, v); check("R8 count load", v, 32'h1234);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule